// File: doc/BRIEF.md
# Packed SIMD Absolute Difference Unit

This block is a lane-parallel integer datapath that works on one register-width slice of packed elements. Each accepted beat carries two source slices and an accumulator slice. It also carries an element-width code, an opcode and a per-element write-enable mask. The block computes one of five operations:

- absolute value of each element;
- absolute difference, with the sources read as signed;
- absolute difference, with the sources read as unsigned;
- signed widening accumulate, which adds the magnitude of each difference into a double-width accumulator element;
- unsigned widening accumulate, the same with the sources read as unsigned.

Every result is a non-negative magnitude. The accumulator slice also supplies the old destination value, so elements whose mask bit is clear come back unchanged.

The legal operations depend on the element width. Absolute value is legal at 8, 16, 32 and 64 bits. The two differences and the two accumulates are legal only at 8 and 16 bits. An illegal width and opcode pair, or a reserved opcode, does not produce a result: the beat comes out with the illegal flag set and the accumulator slice returned unchanged.

Both edges of the block are valid/ready streams with one register stage between them. An input beat is accepted when `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. When the consumer holds `out_ready` low, the output beat stays frozen, and no new input is taken until that beat leaves.

Top module: `absd_simd`

## Requirements
- R1: Opcode 0 (absolute value) is legal at every width code (0=8, 1=16, 2=32, 3=64 bits). It gives the two's-complement magnitude of each element. The most negative value of a width maps to itself.
- R2: Opcode 1 (signed difference) reads each pair of elements as signed and gives |a-b| as an unsigned value of the element width. For 8-bit elements, 0x7F against 0x80 gives 0xFF.
- R3: Opcode 2 (unsigned difference) reads each pair of elements as unsigned and gives |a-b| in the element width.
- R4: Opcodes 3 (signed) and 4 (unsigned) take the source elements from the low half of each source slice. Source element k is paired with the double-width accumulator element k. The accumulator element becomes acc + |a-b|, taken modulo 2^(2*width), with no saturation.
- R5: Opcodes 1 to 4 with width code 2 or 3 set `out_illegal`. The output data then equals the accumulator slice of that beat.
- R6: Opcodes 5, 6 and 7 are reserved at every width. They set `out_illegal`, and the output data equals the accumulator slice.
- R7: Mask bit k enables destination element k. For a widening operation, k counts double-width elements. A destination element whose mask bit is clear keeps its value from the accumulator slice.
- R8: A beat accepted on one clock edge is presented with `out_valid` high right after the next edge. A legal beat has `out_illegal` low.
- R9: While `out_valid` is high and `out_ready` is low, `in_ready` is low, and `out_data` and `out_illegal` hold their values.
- R10: After reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat offered |
| in_ready | output | 1 | Input beat can be taken this cycle |
| in_sew | input | 2 | Element width code: 0=8, 1=16, 2=32, 3=64 bits |
| in_op | input | 3 | Opcode: 0 absolute value, 1 signed difference, 2 unsigned difference, 3 signed accumulate, 4 unsigned accumulate, 5 to 7 reserved |
| in_mask | input | DATA_W/8 | Per-destination-element write enable |
| in_src_a | input | DATA_W | First source slice |
| in_src_b | input | DATA_W | Second source slice (ignored for absolute value) |
| in_acc | input | DATA_W | Accumulator slice and old destination value |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Consumer takes the output beat |
| out_data | output | DATA_W | Result slice |
| out_illegal | output | 1 | Beat used an illegal width and opcode pair, or a reserved opcode; data is the accumulator slice |

## Verification
The candidate results for all four widths are computed in parallel, and a selector picks one of them. A wrong selection, or a wrong sign-extension inside a lane, appears in `out_data` on the cycle right after the beat is accepted. The edge cases expose these faults: the most negative value, differences between values of opposite sign, and accumulator elements close to wrap-around. A fault in the valid or stall state of the output register appears on the ports within one cycle. It shows as a lost beat, a duplicated beat, or data that changes while `out_ready` is held low. The legality decode is checked separately at every width code and reserved opcode. A misdecode shows up as a flipped `out_illegal` on the next beat.

// File: rtl/absd_pkg.sv
package absd_pkg;
  typedef enum logic [2:0] {
    OP_ABS    = 3'd0,
    OP_ABD_S  = 3'd1,
    OP_ABD_U  = 3'd2,
    OP_WACC_S = 3'd3,
    OP_WACC_U = 3'd4
  } absd_op_e;

  localparam int NUM_WIDTHS = 4;
  localparam int WIDE_MAX_SEW = 16;
endpackage

// File: rtl/absd_decode.sv
module absd_decode
  import absd_pkg::*;
(
  input  logic [2:0] op,
  input  logic [1:0] sew,
  output logic       legal
);
  logic is_abs, is_pair_op, narrow_w;

  always_comb begin
    is_abs     = (op == OP_ABS);
    is_pair_op = (op == OP_ABD_S) || (op == OP_ABD_U) ||
                 (op == OP_WACC_S) || (op == OP_WACC_U);
    narrow_w   = (sew == 2'd0) || (sew == 2'd1);
    legal      = is_abs || (is_pair_op && narrow_w);
  end
endmodule

// File: rtl/absd_width.sv
module absd_width
  import absd_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int SEW    = 8
) (
  input  logic [DATA_W-1:0]     src_a,
  input  logic [DATA_W-1:0]     src_b,
  input  logic [DATA_W-1:0]     acc,
  input  logic [DATA_W/SEW-1:0] mask,
  input  logic [2:0]            op,
  output logic [DATA_W-1:0]     res
);
  localparam int N_EL = DATA_W / SEW;
  localparam int W2   = 2 * SEW;

  logic              signed_mode;
  logic              widen_op;
  logic [SEW-1:0]    mag [N_EL];
  logic [DATA_W-1:0] narrow_res;
  logic [DATA_W-1:0] wide_res;

  always_comb begin
    signed_mode = (op == OP_ABD_S) || (op == OP_WACC_S);
    widen_op    = (op == OP_WACC_S) || (op == OP_WACC_U);
  end

  for (genvar e = 0; e < N_EL; e++) begin : g_lane
    logic [SEW-1:0] ea, eb, absv, lane_out;
    logic [SEW:0]   xa, xb, dif;

    always_comb begin
      ea   = src_a[e*SEW +: SEW];
      eb   = src_b[e*SEW +: SEW];
      xa   = {signed_mode & ea[SEW-1], ea};
      xb   = {signed_mode & eb[SEW-1], eb};
      dif  = xa - xb;
      mag[e] = dif[SEW] ? (~dif[SEW-1:0] + 1'b1) : dif[SEW-1:0];
      absv = ea[SEW-1] ? (~ea + 1'b1) : ea;
      lane_out = (op == OP_ABS) ? absv : mag[e];
      narrow_res[e*SEW +: SEW] = mask[e] ? lane_out : acc[e*SEW +: SEW];
    end
  end

  if (SEW <= WIDE_MAX_SEW) begin : g_wide
    localparam int N_WIDE = DATA_W / W2;
    for (genvar k = 0; k < N_WIDE; k++) begin : g_wlane
      logic [W2-1:0] acc_el;
      always_comb begin
        acc_el = acc[k*W2 +: W2];
        wide_res[k*W2 +: W2] = mask[k] ? (acc_el + {{SEW{1'b0}}, mag[k]}) : acc_el;
      end
    end
  end else begin : g_nowide
    always_comb wide_res = acc;
  end

  always_comb res = widen_op ? wide_res : narrow_res;
endmodule

// File: rtl/absd_simd.sv
module absd_simd
  import absd_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [1:0]          in_sew,
  input  logic [2:0]          in_op,
  input  logic [DATA_W/8-1:0] in_mask,
  input  logic [DATA_W-1:0]   in_src_a,
  input  logic [DATA_W-1:0]   in_src_b,
  input  logic [DATA_W-1:0]   in_acc,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [DATA_W-1:0]   out_data,
  output logic                out_illegal
);
  logic [DATA_W-1:0] cand [NUM_WIDTHS];
  logic              legal;
  logic              accept;

  for (genvar g = 0; g < NUM_WIDTHS; g++) begin : g_sew
    localparam int SEW_G = 8 << g;
    absd_width #(.DATA_W(DATA_W), .SEW(SEW_G)) u_w (
      .src_a (in_src_a),
      .src_b (in_src_b),
      .acc   (in_acc),
      .mask  (in_mask[DATA_W/SEW_G-1:0]),
      .op    (in_op),
      .res   (cand[g])
    );
  end

  absd_decode u_dec (.op(in_op), .sew(in_sew), .legal(legal));

  always_comb begin
    in_ready = !out_valid || out_ready;
    accept   = in_valid && in_ready;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_data    <= '0;
      out_illegal <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_data    <= legal ? cand[in_sew] : in_acc;
        out_illegal <= !legal;
      end
    end
  end

  p_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);
  p_abs_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_op == OP_ABS) |=> !out_illegal);
  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_illegal)));
  p_stall_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
  p_reserved_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_op > 3'd4) |=> (out_illegal && out_data == $past(in_acc)));
  p_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_op != 3'd0 && in_op <= 3'd4 && in_sew[1]) |=>
      (out_illegal && out_data == $past(in_acc)));
  p_mask_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_mask == '0) |=> (out_data == $past(in_acc)));
endmodule

// File: tb/sim_absd_simd.sv
`timescale 1ns/1ps
module sim_absd_simd;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ready, out_valid, out_ready, out_illegal;
  logic [1:0]  in_sew;
  logic [2:0]  in_op;
  logic [7:0]  in_mask;
  logic [63:0] in_src_a, in_src_b, in_acc, out_data;
  int n_tests = 0;
  int n_fail  = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  absd_simd #(.DATA_W(64)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sew(in_sew), .in_op(in_op), .in_mask(in_mask), .in_src_a(in_src_a),
    .in_src_b(in_src_b), .in_acc(in_acc), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_illegal(out_illegal)
  );

  task automatic check(string req, logic [64:0] got, logic [64:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [64:0] ref_model(logic [2:0] op, logic [1:0] sew, logic [7:0] mask,
                                            logic [63:0] a, logic [63:0] b, logic [63:0] acc);
    int w = 8 << sew;
    logic [63:0] m = (w == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << w) - 64'd1);
    logic [63:0] res = acc;
    if (op > 3'd4 || (op != 3'd0 && sew > 2'd1)) return {1'b1, acc};
    if (op == 3'd3 || op == 3'd4) begin
      int w2 = 2 * w;
      logic [63:0] m2 = (64'd1 << w2) - 64'd1;
      for (int k = 0; k < 64 / w2; k++) begin
        logic [63:0] x = (a >> (k * w)) & m;
        logic [63:0] y = (b >> (k * w)) & m;
        logic [63:0] mg;
        logic [63:0] ae = (acc >> (k * w2)) & m2;
        if (op == 3'd3) begin
          longint sx = x[w-1] ? longint'(x | ~m) : longint'(x);
          longint sy = y[w-1] ? longint'(y | ~m) : longint'(y);
          mg = (sx > sy) ? 64'(sx - sy) : 64'(sy - sx);
        end else mg = (x > y) ? x - y : y - x;
        if (mask[k]) res = (res & ~(m2 << (k * w2))) | (((ae + mg) & m2) << (k * w2));
      end
      return {1'b0, res};
    end
    for (int e = 0; e < 64 / w; e++) begin
      logic [63:0] x = (a >> (e * w)) & m;
      logic [63:0] y = (b >> (e * w)) & m;
      logic [63:0] v;
      if (op == 3'd0) v = x[w-1] ? ((~x + 64'd1) & m) : x;
      else if (op == 3'd1) begin
        longint sx = x[w-1] ? longint'(x | ~m) : longint'(x);
        longint sy = y[w-1] ? longint'(y | ~m) : longint'(y);
        v = ((sx > sy) ? 64'(sx - sy) : 64'(sy - sx)) & m;
      end else v = (x > y) ? x - y : y - x;
      if (mask[e]) res = (res & ~(m << (e * w))) | (v << (e * w));
    end
    return {1'b0, res};
  endfunction

  task automatic send(string req, logic [2:0] op, logic [1:0] sew, logic [7:0] mask,
                      logic [63:0] a, logic [63:0] b, logic [63:0] acc);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_sew = sew; in_mask = mask;
    in_src_a = a; in_src_b = b; in_acc = acc; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " R8 valid"}, {64'd0, out_valid}, 65'd1);
    check(req, {out_illegal, out_data}, ref_model(op, sew, mask, a, b, acc));
  endtask

  task automatic t_reset;
    check("R10 out_valid", {64'd0, out_valid}, 65'd0);
    check("R10 in_ready", {64'd0, in_ready}, 65'd1);
  endtask

  task automatic t_abs;
    send("R1 abs8", 3'd0, 2'd0, 8'hFF, 64'h807F_FF01_0085_10F0, '0, 64'h1111_2222_3333_4444);
    check("R1 abs8 minval", {1'b0, out_data[63:56]}, 9'h080);
    send("R1 abs16", 3'd0, 2'd1, 8'hFF, 64'h8000_FFFE_7FFF_0003, '0, '0);
    send("R1 abs32", 3'd0, 2'd2, 8'hFF, 64'h8000_0000_FFFF_FFF6, '0, '0);
    send("R1 abs64", 3'd0, 2'd3, 8'hFF, 64'hFFFF_FFFF_FFFF_FFFB, '0, '0);
    check("R1 abs64 value", {1'b0, out_data}, 65'd5);
    send("R1 abs64 minval", 3'd0, 2'd3, 8'hFF, 64'h8000_0000_0000_0000, '0, '0);
  endtask

  task automatic t_abd_signed;
    send("R2 sabd8", 3'd1, 2'd0, 8'hFF, 64'h7F80_0510_FF00_8080, 64'h807F_1005_01FF_7F80, '0);
    check("R2 0x7F-0x80", {1'b0, out_data[63:56]}, 9'h0FF);
    send("R2 sabd16", 3'd1, 2'd1, 8'hFF, 64'h7FFF_8000_1234_FFFF, 64'h8000_7FFF_4321_0001, '0);
  endtask

  task automatic t_abd_unsigned;
    send("R3 uabd8", 3'd2, 2'd0, 8'hFF, 64'h00FF_8070_0102_7F80, 64'hFF00_7080_0201_807F, '0);
    check("R3 0x00-0xFF", {1'b0, out_data[63:56]}, 9'h0FF);
    send("R3 uabd16", 3'd2, 2'd1, 8'hFF, 64'h0000_FFFF_8000_1234, 64'hFFFF_0000_7FFF_1234, '0);
  endtask

  task automatic t_widen;
    send("R4 swacc8", 3'd3, 2'd0, 8'hFF, 64'h5555_5555_7F80_0510, 64'hAAAA_AAAA_807F_1005, 64'h0001_0002_0003_0004);
    send("R4 uwacc8 wrap", 3'd4, 2'd0, 8'hFF, 64'h0000_0000_00FF_1000, 64'h0000_0000_FF00_0010, 64'hFFFF_FF10_0005_FFFF);
    check("R4 wrap lane0", {49'd0, out_data[15:0]}, 65'h0000F);
    send("R4 swacc16", 3'd3, 2'd1, 8'hFF, 64'h0000_0000_7FFF_8000, 64'h0000_0000_8000_7FFF, 64'hFFFF_FFFF_0000_0001);
    send("R4 uwacc16", 3'd4, 2'd1, 8'hFF, 64'h1234_5678_FFFF_0000, 64'h0000_0000_0000_FFFF, 64'h0000_0001_0000_0002);
  endtask

  task automatic t_illegal_width;
    for (int op = 1; op <= 4; op++) begin
      send("R5 wide sew", 3'(op), 2'd2, 8'hFF, 64'h1, 64'h2, 64'hCAFE_F00D_1234_5678);
      check("R5 illegal flag", {64'd0, out_illegal}, 65'd1);
    end
    send("R5 sew64", 3'd1, 2'd3, 8'hFF, 64'h9, 64'h3, 64'hDEAD_BEEF_0000_0001);
  endtask

  task automatic t_reserved;
    for (int op = 5; op <= 7; op++) begin
      send("R6 reserved", 3'(op), 2'd0, 8'hFF, 64'h7, 64'h1, 64'h0123_4567_89AB_CDEF);
      send("R6 reserved sew64", 3'(op), 2'd3, 8'hFF, 64'h7, 64'h1, 64'hFEDC_BA98_7654_3210);
    end
  endtask

  task automatic t_mask;
    send("R7 abs mask", 3'd0, 2'd0, 8'h5A, 64'hF1F2_F3F4_F5F6_F7F8, '0, 64'hAABB_CCDD_EEFF_0011);
    check("R7 lane0 kept", {57'd0, out_data[7:0]}, 65'h11);
    send("R7 widen mask", 3'd4, 2'd0, 8'h05, 64'h0000_0000_1020_3040, 64'h0000_0000_0000_0000, 64'h1000_2000_3000_4000);
    check("R7 wlane1 kept", {49'd0, out_data[31:16]}, 65'h3000);
    send("R7 none", 3'd2, 2'd1, 8'h00, 64'h1111, 64'h2222, 64'h5A5A_5A5A_5A5A_5A5A);
  endtask

  task automatic t_backpressure;
    logic [64:0] exp_a, exp_b;
    exp_a = ref_model(3'd2, 2'd0, 8'hFF, 64'h10, 64'h30, '0);
    exp_b = ref_model(3'd0, 2'd1, 8'hFF, 64'hFFFF, '0, '0);
    @(negedge clk);
    out_ready = 1'b0; in_valid = 1'b1; in_op = 3'd2; in_sew = 2'd0; in_mask = 8'hFF;
    in_src_a = 64'h10; in_src_b = 64'h30; in_acc = '0;
    @(negedge clk);
    in_op = 3'd0; in_sew = 2'd1; in_src_a = 64'hFFFF; in_src_b = '0;
    check("R9 first out", {out_illegal, out_data}, exp_a);
    check("R9 in_ready low", {64'd0, in_ready}, 65'd0);
    repeat (2) @(negedge clk);
    check("R9 held", {out_illegal, out_data}, exp_a);
    check("R9 still valid", {64'd0, out_valid}, 65'd1);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R9 second out", {out_illegal, out_data}, exp_b);
    @(negedge clk);
    check("R9 drained", {64'd0, out_valid}, 65'd0);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1; in_op = '0; in_sew = '0;
    in_mask = '0; in_src_a = '0; in_src_b = '0; in_acc = '0;
    repeat (3) @(posedge clk);
    #1 t_reset();
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_abs();
    t_abd_signed();
    t_abd_unsigned();
    t_widen();
    t_illegal_width();
    t_reserved();
    t_mask();
    t_backpressure();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule